// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Pin Interrupts and Timer Pin Sharing

This block is a small general-purpose I/O port with sixteen pins, set up through three word registers on a plain register bus. A direction register decides which pins the port drives. A data register holds the values driven out, and a read of it returns the synchronised levels seen on the pins. A control register sets up four pin interrupts and two timer hand-over bits.

Pins 0 to 3 can raise interrupts. Each has its own enable and a 3-bit trigger code: low level, high level, rising edge, falling edge or both edges. Level interrupts follow the pin. Edge interrupts are latched until software clears them through the data register. Pins 4 and 5 can be given to two timer outputs. A timer output then drives the pin no matter what the direction and data registers hold.

Top module: `gpio_irq_port`

## Requirements
- R1: The register offsets are 0x0 for direction, 0x4 for control and 0x8 for data. Direction reads back as the 16 bits written. Control reads back bits 17:0 as written and 0 above them. A write takes effect on the next clock edge.
- R2: Direction bit x set to 1 makes pin x an output (`pin_oe[x]`=1). `pin_out[x]` carries bit x of the last value written to the data register.
- R3: A read of offset 0x8 returns the `pin_in` levels through a two-flop synchroniser. A pin change shows on `bus_rdata` after two clock edges.
- R4: Interrupt n (n = 0..3) watches pin n. Control bits [4n+2:4n] hold its trigger code and bit 4n+3 is its enable. `irq[n]` stays 0 while the enable is 0.
- R5: Trigger code 0 asserts `irq[n]` while the synchronised pin is low, and code 1 asserts it while the pin is high. The output follows a pin change two clock edges later.
- R6: Trigger code 2 latches on a rising edge, 4 on a falling edge and 6 on either edge. The latched `irq[n]` rises three clock edges after the pin change and stays high after the pin returns.
- R7: A write to the data register with bit n = 1 clears the edge latch of interrupt n. `irq[n]` is then 0 after that clock edge. A write with bit n = 0 leaves the latch alone.
- R8: Trigger codes 3, 5 and 7 never raise an interrupt, whatever the pin does.
- R9: Control bit 16 hands pin 4 to `tmr_out[0]` and bit 17 hands pin 5 to `tmr_out[1]`. While a bit is set, its pin is an output carrying the timer value, and the direction and data bits for that pin have no effect.
- R10: After reset all registers are zero. Every pin is then an input, `pin_out` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 16 | Levels sampled from the pins |
| pin_out | output | 16 | Values driven to the pins |
| pin_oe | output | 16 | Output enable for each pin |
| tmr_out | input | 2 | Timer outputs that can take over pins 4 and 5 |
| irq | output | 4 | Interrupt requests for pins 0 to 3 |

## Verification
Each result has its own delay. Register writes and latch clears show one edge after the write. Read-back of pin levels and level interrupts show two edges after the pin change. Latched edge interrupts show three edges after it. Timer hand-over and the read mux are combinational, so they show at once. The driver steps whole clock periods by these counts and pushes each expectation only after the last edge has passed, so a check falls in the cycle its result is due. Where it matters, the bench also checks one edge early to confirm the output has not yet changed.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS    = 16,
  parameter int NIRQ     = 4,
  parameter int NTMR     = 2,
  parameter int TMR_BASE = 4,
  parameter int DW       = 32,
  parameter int AW       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic [NTMR-1:0]  tmr_out,
  output logic [NIRQ-1:0]  irq
);
  localparam int TEN_LSB = 4 * NIRQ;
  localparam int CTRL_W  = TEN_LSB + NTMR;
  localparam logic [AW-1:0] OFS_DIR  = AW'(4'h0);
  localparam logic [AW-1:0] OFS_CTRL = AW'(4'h4);
  localparam logic [AW-1:0] OFS_DATA = AW'(4'h8);

  logic [NPINS-1:0]  dir_q, dout_q, sync1_q, sync2_q, prev_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NIRQ-1:0]   lat_q, edge_hit, lvl_hit, is_edge;
  logic [1:0]        age_q;

  wire wr_dir  = bus_en && bus_we && (bus_addr == OFS_DIR);
  wire wr_ctrl = bus_en && bus_we && (bus_addr == OFS_CTRL);
  wire wr_data = bus_en && bus_we && (bus_addr == OFS_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dout_q  <= '0;
      ctrl_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      lat_q   <= '0;
      age_q   <= '0;
    end else begin
      if (wr_dir)  dir_q  <= bus_wdata[NPINS-1:0];
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_data) dout_q <= bus_wdata[NPINS-1:0];
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      lat_q   <= (lat_q & ~(wr_data ? bus_wdata[NIRQ-1:0] : '0)) | edge_hit;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  for (genvar n = 0; n < NIRQ; n++) begin : g_irq
    wire [2:0] tm   = ctrl_q[4*n +: 3];
    wire       en   = ctrl_q[4*n+3];
    wire       s    = sync2_q[n];
    wire       rise = s & ~prev_q[n];
    wire       fall = ~s & prev_q[n];

    assign lvl_hit[n]  = (tm == 3'd0) ? ~s : (tm == 3'd1) ? s : 1'b0;
    assign is_edge[n]  = (tm == 3'd2) || (tm == 3'd4) || (tm == 3'd6);
    assign edge_hit[n] = en & is_edge[n] & ((tm[1] & rise) | (tm[2] & fall));
    assign irq[n]      = en & (lvl_hit[n] | (is_edge[n] & lat_q[n]));

    assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tm == 3'd3 || tm == 3'd5 || tm == 3'd7) |-> !irq[n]);
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !irq[n]);
    assert_clear_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && bus_wdata[n] && !edge_hit[n]) |=> !lat_q[n]);
  end

  always_comb begin
    pin_out = dout_q;
    pin_oe  = dir_q;
    for (int t = 0; t < NTMR; t++) begin
      if (ctrl_q[TEN_LSB+t]) begin
        pin_out[TMR_BASE+t] = tmr_out[t];
        pin_oe[TMR_BASE+t]  = 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        OFS_DIR:  bus_rdata[NPINS-1:0]  = dir_q;
        OFS_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
        OFS_DATA: bus_rdata[NPINS-1:0]  = sync2_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe[NPINS-1:TMR_BASE+NTMR] == $past(bus_wdata[NPINS-1:TMR_BASE+NTMR]));
  assert_pin_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && bus_en && !bus_we && bus_addr == OFS_DATA)
      |-> bus_rdata[NPINS-1:0] == $past(pin_in, 2));
  assert_timer_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[TEN_LSB] |-> (pin_oe[TMR_BASE] && pin_out[TMR_BASE] == tmr_out[0]));

endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  logic        clk = 0, rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] pin_in = '0, pin_out, pin_oe;
  logic [1:0]  tmr_out = '0;
  logic [3:0]  irq;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .tmr_out(tmr_out), .irq(irq));

  always #5 clk = ~clk;

  typedef enum int {SEL_RD, SEL_OUT, SEL_OE, SEL_IRQ} sel_e;
  typedef struct { string req; sel_e sel; logic [31:0] exp; } item_t;
  item_t q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  task automatic push(string req, sel_e sel, logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    bus_en = 1; bus_we = 0; bus_addr = a;
    push(req, SEL_RD, exp);
    tick(1);
    bus_en = 0;
  endtask

  task automatic chk(string req, sel_e sel, logic [31:0] exp);
    push(req, sel, exp);
    tick(1);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        SEL_RD:  act = bus_rdata;
        SEL_OUT: act = {16'h0, pin_out};
        SEL_OE:  act = {16'h0, pin_oe};
        default: act = {28'h0, irq};
      endcase
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R10 reset state
    chk("R10", SEL_OE, 32'h0);
    chk("R10", SEL_OUT, 32'h0);
    chk("R10", SEL_IRQ, 32'h0);
    rd("R10", 4'h4, 32'h0);
    // R1 register map and read-back
    wr(4'h0, 32'hFFFF_00F0);
    rd("R1", 4'h0, 32'h0000_00F0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd("R1", 4'h4, 32'h0003_FFFF);
    chk("R8", SEL_IRQ, 32'h0);
    wr(4'h4, 32'h0);
    // R2 direction and output data
    wr(4'h0, 32'h0000_00FF);
    wr(4'h8, 32'h0000_A550);
    chk("R2", SEL_OE, 32'h0000_00FF);
    chk("R2", SEL_OUT, 32'h0000_A550);
    // R3 synchronised read-back
    pin_in = 16'h1230;
    tick(1);
    rd("R3", 4'h8, 32'h0);
    rd("R3", 4'h8, 32'h0000_1230);
    pin_in = 16'h0000;
    tick(3);
    // R5 level modes
    wr(4'h4, 32'h0000_0008);
    chk("R5", SEL_IRQ, 32'h1);
    pin_in[0] = 1;
    tick(1);
    chk("R5", SEL_IRQ, 32'h1);
    chk("R5", SEL_IRQ, 32'h0);
    wr(4'h4, 32'h0000_0098);
    chk("R5", SEL_IRQ, 32'h0);
    pin_in[1] = 1;
    tick(2);
    chk("R5", SEL_IRQ, 32'h2);
    // R4 disabled slice stays quiet
    pin_in = 16'h0;
    wr(4'h4, 32'h0000_0000);
    tick(3);
    chk("R4", SEL_IRQ, 32'h0);
    // R6 rising on pin 2, falling on pin 3
    wr(4'h4, 32'h0000_CA00);
    pin_in[2] = 1;
    tick(2);
    chk("R6", SEL_IRQ, 32'h0);
    chk("R6", SEL_IRQ, 32'h4);
    pin_in[2] = 0;
    pin_in[3] = 1;
    tick(3);
    chk("R6", SEL_IRQ, 32'h4);
    pin_in[3] = 0;
    tick(3);
    chk("R6", SEL_IRQ, 32'hC);
    // R7 clear by writing ones to data
    wr(4'h8, 32'h0);
    chk("R7", SEL_IRQ, 32'hC);
    wr(4'h8, 32'h4);
    chk("R7", SEL_IRQ, 32'h8);
    wr(4'h8, 32'h8);
    chk("R7", SEL_IRQ, 32'h0);
    // R6 both edges on pin 2
    wr(4'h4, 32'h0000_0E00);
    pin_in[2] = 1;
    tick(3);
    chk("R6", SEL_IRQ, 32'h4);
    wr(4'h8, 32'h4);
    chk("R7", SEL_IRQ, 32'h0);
    pin_in[2] = 0;
    tick(3);
    chk("R6", SEL_IRQ, 32'h4);
    wr(4'h8, 32'h4);
    // R8 reserved codes
    wr(4'h4, 32'h0000_0FDB);
    pin_in[2:0] = 3'b111;
    tick(1);
    chk("R8", SEL_IRQ, 32'h0);
    tick(2);
    chk("R8", SEL_IRQ, 32'h0);
    pin_in[2:0] = 3'b000;
    tick(3);
    chk("R8", SEL_IRQ, 32'h0);
    // R9 timer hand-over
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h0);
    wr(4'h4, 32'h0001_0000);
    tmr_out = 2'b01;
    chk("R9", SEL_OE, 32'h0000_0010);
    chk("R9", SEL_OUT, 32'h0000_0010);
    tmr_out = 2'b00;
    chk("R9", SEL_OUT, 32'h0000_0000);
    wr(4'h0, 32'hFFFF);
    wr(4'h8, 32'hFFFF);
    wr(4'h4, 32'h0003_0000);
    tmr_out = 2'b10;
    chk("R9", SEL_OUT, 32'h0000_FFEF);
    chk("R9", SEL_OE, 32'h0000_FFFF);
    tick(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule